// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches the value of a timer counter and reports when the value equals a programmable compare value. The counter itself lives outside the block. The unit receives the count, a per-tick enable and indications of the top and bottom of the count sequence, together with a two-bit waveform mode. An equality hit latches a compare flag on the timer tick where the hit occurs, so the flag becomes visible one cycle after the compare. When the interrupt enable is set, the flag raises an interrupt request. The flag is cleared by an interrupt acknowledge or by a software write of one.

The compare value is held in two registers: an active register that drives the comparator, and a buffer register. In the two PWM modes a CPU write lands only in the buffer. The buffer is copied into the active register at a count extreme: the top for phase-correct PWM and the bottom for fast PWM. This keeps pulse widths from changing part-way through a period. In normal and clear-on-compare modes a write updates the active register at once. The block exports the active compare value for the waveform logic that follows it. It also provides a CPU read-back path.

Top module: `tmr_match_unit`

## Requirements
- R1: `match` is high in the same cycle as `count` equals the active compare value (`cmp_value`), and low otherwise. The comparison is combinational.
- R2: A clock edge with `tick_en` high and `match` high sets `flag`. The flag is therefore first seen high in the cycle after the equality, not in the equality cycle.
- R3: `flag` changes only at clock edges where `tick_en` is high. Sets, acknowledges and software clears are all ignored at edges where `tick_en` is low.
- R4: `irq` is high exactly when `flag` is high and `int_en` is high.
- R5: `int_ack` high at a tick edge clears `flag`.
- R6: A write with `flag_wr` high clears `flag` at a tick edge when `flag_wr_data` is 1. It leaves `flag` unchanged when `flag_wr_data` is 0.
- R7: If a set and a clear (acknowledge or software clear) meet at the same tick edge, the flag ends up set.
- R8: `mode` encoding is 00 normal, 01 phase-correct PWM, 10 clear-on-compare, 11 fast PWM. In modes 00 and 10 a write (`wr_en`) updates `cmp_value` at the next clock edge.
- R9: In mode 01 a write goes only to the buffer. The buffer is copied to `cmp_value` at an edge where `tick_en` and `at_top` are both high. `at_bottom` does not cause a copy in this mode.
- R10: In mode 11 the buffer is copied at an edge where `tick_en` and `at_bottom` are both high. `at_top` does not cause a copy in this mode.
- R11: `rd_data` returns the buffer in modes 01 and 11, and returns the active register in modes 00 and 10.
- R12: While reset is held, `cmp_value`, `rd_data`, `flag`, `irq` and `match` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable; qualifies flag updates and buffer copies |
| count | input | CNT_W | Current timer count |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| mode | input | 2 | Waveform mode (00 normal, 01 phase-correct PWM, 10 CTC, 11 fast PWM) |
| wr_en | input | 1 | CPU write strobe for the compare value |
| wr_data | input | CNT_W | CPU write data for the compare value |
| rd_data | output | CNT_W | CPU read-back of the compare value |
| flag_wr | input | 1 | CPU write strobe for the flag bit |
| flag_wr_data | input | 1 | Flag write data; 1 clears the flag |
| int_en | input | 1 | Compare interrupt enable |
| int_ack | input | 1 | Interrupt acknowledge; clears the flag |
| match | output | 1 | Count equals the active compare value |
| flag | output | 1 | Latched compare flag |
| irq | output | 1 | Interrupt request |
| cmp_value | output | CNT_W | Active compare value |

## Verification
The hardest situation to reach is the one where the buffer and the active register hold different values at the moment a count extreme arrives in the wrong mode. The stimulus loads a known value in a direct mode and switches to a PWM mode. It then writes a different value and presents the extreme of the other mode before the correct one. Between those steps it checks `cmp_value`, `rd_data` and `match` against the buffered count. The bench also sweeps all 256 counts against several compare values while `tick_en` is low. It then confirms that the flag stayed clear, and forces sets and clears onto the same tick edge.

// File: rtl/tmr_match_pkg.sv
package tmr_match_pkg;

   typedef enum logic [1:0] {
      WAVE_NORMAL   = 2'b00,
      WAVE_PC_PWM   = 2'b01,
      WAVE_CTC      = 2'b10,
      WAVE_FAST_PWM = 2'b11
   } wave_mode_e;

   // PWM modes are the ones with the low mode bit set
   function automatic logic mode_is_buffered(input logic [1:0] m);
      return (m == WAVE_PC_PWM) || (m == WAVE_FAST_PWM);
   endfunction

   // Extreme that triggers a buffer copy in a buffered mode
   function automatic logic copy_point(input logic [1:0] m,
                                       input logic       top,
                                       input logic       bottom);
      logic r;
      case (m)
         WAVE_PC_PWM:   r = top;
         WAVE_FAST_PWM: r = bottom;
         default:       r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tmr_match_cmp.sv
module tmr_match_cmp #(
   parameter int CNT_W = 8
) (
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] cmp_value,
   output logic             hit
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tmr_match_cmp: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] diff;

   always_comb begin
      diff = count ^ cmp_value;
      hit  = rst_n && (diff == '0);
   end
endmodule

// File: rtl/tmr_match_flag.sv
module tmr_match_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic hit,
   input  logic clr_sw,
   input  logic clr_ack,
   output logic flag
);
   logic flag_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (tick_en) begin
         if (hit)
            flag_d = 1'b1;
         else if (clr_sw || clr_ack)
            flag_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(flag_q));

   // R7
   flag_set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en && hit |=> flag_q);

   // R5
   flag_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en && clr_ack && !hit |=> !flag_q);
endmodule

// File: rtl/tmr_match_regs.sv
module tmr_match_regs
   import tmr_match_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit DBL_BUF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             at_top,
   input  logic             at_bottom,
   input  logic [1:0]       mode,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic             buffered,
   output logic [CNT_W-1:0] active,
   output logic [CNT_W-1:0] shadow
);
   logic [CNT_W-1:0] active_q;
   logic [CNT_W-1:0] shadow_q;
   logic             load_now;

   generate
      if (DBL_BUF) begin : g_dbl
         always_comb begin
            buffered = mode_is_buffered(mode);
            load_now = buffered && tick_en && copy_point(mode, at_top, at_bottom);
         end
      end else begin : g_direct
         always_comb begin
            buffered = 1'b0;
            load_now = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr_en) begin
         shadow_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
      end else if (!buffered && wr_en) begin
         active_q <= wr_data;
      end else if (load_now) begin
         active_q <= shadow_q;
      end
   end

   assign active = active_q;
   assign shadow = shadow_q;

   // R8
   direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !buffered && wr_en |=> active_q == $past(wr_data));

   // R9
   buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buffered && !(tick_en && (at_top || at_bottom)) |=> $stable(active_q));
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
   import tmr_match_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit DBL_BUF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] count,
   input  logic             at_top,
   input  logic             at_bottom,
   input  logic [1:0]       mode,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] rd_data,
   input  logic             flag_wr,
   input  logic             flag_wr_data,
   input  logic             int_en,
   input  logic             int_ack,
   output logic             match,
   output logic             flag,
   output logic             irq,
   output logic [CNT_W-1:0] cmp_value
);
   logic             buffered;
   logic [CNT_W-1:0] active;
   logic [CNT_W-1:0] shadow;
   logic             hit;
   logic             clr_sw;

   tmr_match_regs #(.CNT_W(CNT_W), .DBL_BUF(DBL_BUF)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .at_top    (at_top),
      .at_bottom (at_bottom),
      .mode      (mode),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .buffered  (buffered),
      .active    (active),
      .shadow    (shadow)
   );

   tmr_match_cmp #(.CNT_W(CNT_W)) u_cmp (
      .rst_n     (rst_n),
      .count     (count),
      .cmp_value (active),
      .hit       (hit)
   );

   assign clr_sw = flag_wr && flag_wr_data;

   tmr_match_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .hit     (hit),
      .clr_sw  (clr_sw),
      .clr_ack (int_ack),
      .flag    (flag)
   );

   always_comb begin
      match     = hit;
      irq       = flag && int_en;
      cmp_value = active;
      rd_data   = buffered ? shadow : active;
   end

   // R2
   flag_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(match && tick_en));
endmodule

// File: tb/tmr_match_unit_tb.sv
module tmr_match_unit_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         tick_en;
   logic [W-1:0] count;
   logic         at_top;
   logic         at_bottom;
   logic [1:0]   mode;
   logic         wr_en;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data;
   logic         flag_wr;
   logic         flag_wr_data;
   logic         int_en;
   logic         int_ack;
   logic         match;
   logic         flag;
   logic         irq;
   logic [W-1:0] cmp_value;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   tmr_match_unit #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count),
      .at_top(at_top), .at_bottom(at_bottom), .mode(mode),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .flag_wr(flag_wr), .flag_wr_data(flag_wr_data),
      .int_en(int_en), .int_ack(int_ack),
      .match(match), .flag(flag), .irq(irq), .cmp_value(cmp_value)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock edge; returns just after the following falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      tick_en = 0; wr_en = 0; flag_wr = 0; flag_wr_data = 0;
      int_ack = 0; at_top = 0; at_bottom = 0;
   endtask

   task automatic write_cmp(input logic [W-1:0] v);
      wr_en = 1; wr_data = v;
      step();
      wr_en = 0;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] vals [6] = '{8'h00, 8'h01, 8'h55, 8'hAA, 8'hFE, 8'hFF};
      idle();
      rst_n = 0; count = 0; mode = 2'b00; wr_data = 0; int_en = 1;
      repeat (2) @(negedge clk);
      // R12 reset state
      chk("R12 cmp_value", cmp_value, 0);
      chk("R12 rd_data", rd_data, 0);
      chk("R12 flag", flag, 0);
      chk("R12 irq", irq, 0);
      chk("R12 match", match, 0);
      rst_n = 1;
      step();

      // R1 and R3: full count sweep per compare value, ticks held low
      foreach (vals[i]) begin
         mode = (i % 2 == 0) ? 2'b00 : 2'b10;
         write_cmp(vals[i]);
         chk("R8 direct write", cmp_value, vals[i]);
         chk("R11 read-back direct", rd_data, vals[i]);
         for (int c = 0; c < 256; c++) begin
            count = W'(c);
            #1;
            chk("R1 match", match, (c == vals[i]) ? 1 : 0);
            step();
         end
         chk("R3 no set without tick", flag, 0);
      end

      // R2 set timing
      mode = 2'b00;
      write_cmp(8'h3C);
      count = 8'h3C; tick_en = 1;
      #1;
      chk("R2 flag not yet set", flag, 0);
      step();
      tick_en = 0; count = 8'h00;
      chk("R2 flag set next cycle", flag, 1);
      // R4 irq gating
      int_en = 0; #1;
      chk("R4 irq disabled", irq, 0);
      int_en = 1; #1;
      chk("R4 irq enabled", irq, 1);

      // R6 write zero ignored, write one clears
      tick_en = 1; flag_wr = 1; flag_wr_data = 0;
      step();
      chk("R6 write zero keeps flag", flag, 1);
      flag_wr_data = 1;
      step();
      idle();
      chk("R6 write one clears", flag, 0);

      // R5 ack, R3 ack ignored without tick
      count = 8'h3C; tick_en = 1; step();
      count = 8'h00; idle();
      chk("R2 flag set again", flag, 1);
      int_ack = 1; step();
      chk("R3 ack ignored without tick", flag, 1);
      tick_en = 1; step();
      idle();
      chk("R5 ack clears", flag, 0);
      chk("R4 irq low after clear", irq, 0);

      // R7 set beats clear
      count = 8'h3C; tick_en = 1; int_ack = 1; flag_wr = 1; flag_wr_data = 1;
      step();
      idle(); count = 8'h00;
      chk("R7 set priority", flag, 1);
      tick_en = 1; int_ack = 1; step(); idle();

      // R9 phase-correct PWM
      mode = 2'b10; write_cmp(8'h20);
      mode = 2'b01; write_cmp(8'h90);
      chk("R9 buffered write held", cmp_value, 8'h20);
      chk("R11 read-back buffer", rd_data, 8'h90);
      count = 8'h90; #1;
      chk("R9 match uses active value", match, 0);
      count = 8'h00;
      at_bottom = 1; tick_en = 1; step(); idle();
      chk("R9 bottom ignored", cmp_value, 8'h20);
      at_top = 1; step(); idle();
      chk("R9 top without tick ignored", cmp_value, 8'h20);
      at_top = 1; tick_en = 1; step(); idle();
      chk("R9 top copy", cmp_value, 8'h90);

      // R10 fast PWM
      mode = 2'b11; write_cmp(8'h47);
      chk("R10 buffered write held", cmp_value, 8'h90);
      at_top = 1; tick_en = 1; step(); idle();
      chk("R10 top ignored", cmp_value, 8'h90);
      at_bottom = 1; tick_en = 1; step(); idle();
      chk("R10 bottom copy", cmp_value, 8'h47);
      mode = 2'b00; #1;
      chk("R11 read-back active", rd_data, 8'h47);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule